// File: doc/BRIEF.md
# Gated and compare 16-bit up-counting timer

This block is a 16-bit up-counter driven by a power-of-two prescaler of the system clock. It has two modes. In compare mode it counts freely from a start value that software loads. It flags a match each time the count lands on the value in the reload register, then keeps counting. In gated mode it counts only while the synchronised timer input sits at a programmable active level. When the count meets the reload value it restarts at 0001h, and it also flags the moment the input leaves its active level.

Software sets up the block through a small write port with three addresses: control, count and reload. Configuration is done while the timer is disabled; setting the enable bit starts counting. The block drives a timer output level, which inverts on every match or restart, and a one-clock interrupt pulse. Both causes of an interrupt share that pulse. Software can tell them apart by comparing the input pin with the polarity bit.

Top module: `gct_timer`

## Requirements
- R1: After reset the count reads 0000h, the timer output is low, the interrupt is low and every control field is zero.
- R2: Address 0 is the control register, with bit 0 enable, bit 1 mode (1 gated, 0 compare), bits 4:2 prescale exponent n, bit 5 initial output level and bit 6 gate active level (1 active high). Address 1 is the count register and address 2 the reload/compare register. A write lands on the clock edge where wrEn is high.
- R3: While enable is clear the count holds, unless software writes it, and the timer output takes the initial level bit one clock after the control register holds it.
- R4: A count write takes effect at that edge while the timer is disabled, and is ignored while it is enabled.
- R5: The count advances once every 2^n clocks. The first advance comes 2^n clocks after the edge that sets enable. The prescaler is cleared whenever enable is clear.
- R6: In compare mode the count advances whatever the timer input does. When an advance makes the count equal the reload value, the interrupt pulses and the output inverts. The count wraps from FFFFh to 0000h with no event.
- R7: In gated mode the count and the prescaler advance only while the timer input, after a two-flop synchroniser, equals the gate active level.
- R8: In gated mode an advance taken while the count equals the reload value loads 0001h, pulses the interrupt and inverts the output.
- R9: In gated mode with enable set, the interrupt pulses one clock after the synchronised input leaves the active level.
- R10: The interrupt is a one-clock pulse per event. A restart and a gate release in the same clock give a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 count, 2 reload |
| wrData | input | 16 | Register write data |
| timerIn | input | 1 | Asynchronous timer gate input |
| count | output | 16 | Current count value |
| timerOut | output | 1 | Timer output level |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The properties assume that the write port follows the register map, so that at most one register is written per clock, and that a count write while enabled is a normal event that must leave the count alone. They assume timerIn may change on any cycle, because the synchroniser and the gate-release detection are checked only after it. The stimulus keeps writes sparse, keeps the prescale exponent small and the reload values low, so that matches, restarts and gate releases occur often. It also toggles timerIn at random, so that gate releases sometimes coincide with restarts.

// File: rtl/gct_pkg.sv
package gct_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd2;

  // control bit positions; prescale field starts at BIT_PS_LO and the
  // initial-level and polarity bits follow it
  localparam int BIT_EN    = 0;
  localparam int BIT_MODE  = 1;
  localparam int BIT_PS_LO = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic enabled;
    logic gatedMode;
    logic initLvl;
    logic step;
    logic gateFall;
    logic wrCount;
    logic wrReload;
  } strobe_t;

endpackage

// File: rtl/gct_sync.sv
module gct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/gct_ctrl.sv
module gct_ctrl
  import gct_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timerIn,
  output strobe_t           stb
);

  localparam int PSC_W    = (1 << PS_W) - 1;
  localparam int INIT_BIT = BIT_PS_LO + PS_W;
  localparam int POL_BIT  = INIT_BIT + 1;

  logic             enReg, gatedReg, initReg, polReg;
  logic [PS_W-1:0]  psSel;
  logic [PSC_W-1:0] psCnt, psLimit;
  logic             gateSync, gateActive, prevActive;
  logic             run, tick, ctrlWr;

  gct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (timerIn),
    .dout (gateSync)
  );

  assign ctrlWr     = wrEn && (wrAddr == ADDR_CTRL);
  assign gateActive = (gateSync == polReg);
  assign run        = enReg && (!gatedReg || gateActive);
  assign psLimit    = ~({PSC_W{1'b1}} << psSel);
  assign tick       = run && (psCnt == psLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      gatedReg <= 1'b0;
      initReg  <= 1'b0;
      polReg   <= 1'b0;
      psSel    <= '0;
    end else if (ctrlWr) begin
      enReg    <= wrData[BIT_EN];
      gatedReg <= wrData[BIT_MODE];
      psSel    <= wrData[BIT_PS_LO +: PS_W];
      initReg  <= wrData[INIT_BIT];
      polReg   <= wrData[POL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt      <= '0;
      prevActive <= 1'b0;
    end else begin
      prevActive <= gateActive;
      if (!enReg)    psCnt <= '0;
      else if (tick) psCnt <= '0;
      else if (run)  psCnt <= psCnt + 1'b1;
    end
  end

  assign stb.enabled   = enReg;
  assign stb.gatedMode = gatedReg;
  assign stb.initLvl   = initReg;
  assign stb.step      = tick;
  assign stb.gateFall  = enReg && gatedReg && prevActive && !gateActive;
  assign stb.wrCount   = wrEn && (wrAddr == ADDR_COUNT) && !enReg;
  assign stb.wrReload  = wrEn && (wrAddr == ADDR_RELOAD);

endmodule

// File: rtl/gct_dp.sv
module gct_dp
  import gct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             timerOut,
  output logic             irq
);

  localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

  logic [CNT_W-1:0] cntReg, reloadReg, cntInc;
  logic             atReload, incMatch, hit, outLvl, irqReg;

  assign cntInc   = cntReg + 1'b1;
  assign atReload = (cntReg == reloadReg);
  assign incMatch = (cntInc == reloadReg);
  assign hit      = stb.step && (stb.gatedMode ? atReload : incMatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg    <= '0;
      reloadReg <= '0;
      outLvl    <= 1'b0;
      irqReg    <= 1'b0;
    end else begin
      if (stb.wrCount)
        cntReg <= wrData;
      else if (stb.step)
        cntReg <= (stb.gatedMode && atReload) ? RESTART : cntInc;

      if (stb.wrReload)
        reloadReg <= wrData;

      if (!stb.enabled) outLvl <= stb.initLvl;
      else if (hit)     outLvl <= !outLvl;

      irqReg <= hit || stb.gateFall;
    end
  end

  assign count    = cntReg;
  assign timerOut = outLvl;
  assign irq      = irqReg;

endmodule

// File: rtl/gct_timer.sv
module gct_timer
  import gct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              timerIn,
  output logic [CNT_W-1:0]  count,
  output logic              timerOut,
  output logic              irq
);

  strobe_t stb;

  gct_ctrl #(
    .DATA_W      (CNT_W),
    .PS_W        (PS_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .timerIn (timerIn),
    .stb     (stb)
  );

  gct_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .count    (count),
    .timerOut (timerOut),
    .irq      (irq)
  );

endmodule

// File: rtl/gct_timer_chk.sv
module gct_timer_chk
  import gct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  wrData,
  input logic [CNT_W-1:0]  count,
  input logic              timerOut,
  input logic              irq,
  input strobe_t           stb
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.enabled && !stb.wrCount) |=> $stable(count));

  a_r3_out_init: assert property (@(posedge clk) disable iff (!rstN)
    !stb.enabled |=> (timerOut == $past(stb.initLvl)));

  a_r4_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCount |=> (count == $past(wrData)));

  a_r4_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_COUNT && stb.enabled && !stb.step) |=> $stable(count));

  a_r6_no_step_no_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enabled && !stb.step) |=> $stable(timerOut));

  a_r8_restart_or_inc: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && stb.gatedMode) |=> (count == ONE || count == CNT_W'($past(count) + 1'b1)));

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(stb.step || stb.gateFall));

endmodule

bind gct_timer gct_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .count    (count),
  .timerOut (timerOut),
  .irq      (irq),
  .stb      (stb)
);

// File: tb/gct_timer_test.sv
`timescale 1ns/1ps
module gct_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        timerIn = 1'b0;
  logic [15:0] count;
  logic        timerOut, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gct_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerIn(timerIn), .count(count), .timerOut(timerOut), .irq(irq)
  );

  // reference state built from the requirements
  logic        mEn, mGated, mInit, mPol;
  logic [2:0]  mPs;
  logic [15:0] mCount, mReload;
  logic [6:0]  mPsc;
  logic        mOut, mIrq, mS1, mS2, mPrev;
  logic        mAct, mRun, mTick, mFall, mHit;

  function automatic logic [6:0] psLimitF(input logic [2:0] n);
    return 7'((8'd1 << n) - 8'd1);
  endfunction

  function automatic logic [15:0] nextCountF(input logic [15:0] c, input logic [15:0] r,
                                             input logic gated);
    if (gated && c == r) return 16'h0001;
    return c + 16'h0001;
  endfunction

  function automatic logic hitF(input logic [15:0] c, input logic [15:0] r, input logic gated);
    if (gated) return c == r;
    return (c + 16'h0001) == r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEn <= 0; mGated <= 0; mInit <= 0; mPol <= 0; mPs <= 0;
      mCount <= 0; mReload <= 0; mPsc <= 0; mOut <= 0; mIrq <= 0;
      mS1 <= 0; mS2 <= 0; mPrev <= 0;
    end else begin
      mAct  = (mS2 == mPol);
      mRun  = mEn && (!mGated || mAct);
      mTick = mRun && (mPsc == psLimitF(mPs));
      mFall = mEn && mGated && mPrev && !mAct;
      mHit  = mTick && hitF(mCount, mReload, mGated);
      mS1 <= timerIn;
      mS2 <= mS1;
      mPrev <= mAct;
      if (!mEn) mPsc <= 0;
      else if (mTick) mPsc <= 0;
      else if (mRun) mPsc <= mPsc + 1;
      if (wrEn && wrAddr == 2'd1 && !mEn) mCount <= wrData;
      else if (mTick) mCount <= nextCountF(mCount, mReload, mGated);
      if (wrEn && wrAddr == 2'd2) mReload <= wrData;
      if (wrEn && wrAddr == 2'd0) begin
        mEn <= wrData[0]; mGated <= wrData[1]; mPs <= wrData[4:2];
        mInit <= wrData[5]; mPol <= wrData[6];
      end
      mOut <= !mEn ? mInit : (mHit ? !mOut : mOut);
      mIrq <= mHit || mFall;
    end
  end

  task automatic cyc(input string tag);
    @(negedge clk);
    checks++;
    if (count !== mCount || timerOut !== mOut || irq !== mIrq) begin
      errors++;
      $display("FAIL %s: count=%h out=%b irq=%b, expected count=%h out=%b irq=%b",
               tag, count, timerOut, irq, mCount, mOut, mIrq);
    end
    wrEn = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
    cyc(tag);
    wrEn = 1'b1; wrAddr = a; wrData = d;
  endtask

  task automatic dchk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: ran %0d cycles, expected completion earlier", 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc("R1");
    dchk("R1 count", count, 16'h0000);
    dchk("R1 out", {15'd0, timerOut}, 16'd0);
    dchk("R1 irq", {15'd0, irq}, 16'd0);

    // R3: disabled output follows init level
    wr(2'd0, 16'h0020, "R3");
    cyc("R3"); cyc("R3");
    dchk("R3 init level", {15'd0, timerOut}, 16'd1);

    // R4: load while disabled
    wr(2'd1, 16'hFFFD, "R4");
    cyc("R4");
    dchk("R4 load", count, 16'hFFFD);

    // R6: compare mode wrap without event, then match at 0001h
    wr(2'd2, 16'h0001, "R6");
    wr(2'd0, 16'h0021, "R6");
    for (int i = 0; i < 10 && count != 16'h0000; i++) cyc("R6");
    dchk("R6 wrap count", count, 16'h0000);
    dchk("R6 wrap no irq", {15'd0, irq}, 16'd0);
    cyc("R6");
    dchk("R6 match count", count, 16'h0001);
    dchk("R6 match irq", {15'd0, irq}, 16'd1);
    dchk("R6 match toggle", {15'd0, timerOut}, 16'd0);

    // R4: write ignored while enabled
    wr(2'd1, 16'h1234, "R4");
    cyc("R4");
    dchk("R4 ignored", count, 16'h0003);

    // R5: prescale by 4
    wr(2'd0, 16'h0000, "R5");
    wr(2'd1, 16'h0000, "R5");
    wr(2'd2, 16'h0010, "R5");
    wr(2'd0, 16'h0009, "R5");
    for (int i = 0; i < 4; i++) cyc("R5");
    dchk("R5 before first step", count, 16'h0000);
    cyc("R5");
    dchk("R5 first step", count, 16'h0001);
    for (int i = 0; i < 4; i++) cyc("R5");
    dchk("R5 second step", count, 16'h0002);
    for (int i = 0; i < 40; i++) begin
      timerIn = 1'(i[2]);
      cyc("R6");
    end

    // R7/R8/R9: gated, active high, reload 3
    wr(2'd0, 16'h0000, "R7");
    timerIn = 1'b0;
    wr(2'd1, 16'h0000, "R7");
    wr(2'd2, 16'h0003, "R8");
    wr(2'd0, 16'h0043, "R7");
    for (int i = 0; i < 6; i++) cyc("R7");
    dchk("R7 gate closed", count, 16'h0000);
    timerIn = 1'b1;
    for (int i = 0; i < 30; i++) cyc("R8");
    for (int k = 0; k < 8; k++) begin
      timerIn = 1'b0;
      for (int i = 0; i < 5; i++) cyc("R9");
      timerIn = 1'b1;
      for (int i = 0; i < 7 + k; i++) cyc("R9");
    end

    // R7: gated active low
    wr(2'd0, 16'h0000, "R7");
    wr(2'd0, 16'h0003, "R7");
    for (int i = 0; i < 60; i++) begin
      timerIn = 1'(i[3]);
      cyc("R7");
    end

    // R2/R10: random mix
    for (int i = 0; i < 20000; i++) begin
      int unsigned pick;
      pick = $urandom_range(0, 99);
      if ($urandom_range(0, 9) == 0) timerIn = ~timerIn;
      if (pick < 2)
        wr(2'd0, 16'({$urandom_range(0, 1), $urandom_range(0, 1), 3'($urandom_range(0, 2)),
                       $urandom_range(0, 1), $urandom_range(0, 1)}), "R2");
      else if (pick < 4) wr(2'd1, 16'($urandom_range(0, 12)), "R4");
      else if (pick < 6) wr(2'd2, 16'($urandom_range(0, 12)), "R10");
      else cyc("R10");
    end
    cyc("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule